// File: doc/BRIEF.md
# Mezzanine Interrupt Request Conditioner and Delivery Selector

This block sits between a plug-in module's two active-low interrupt request lines and the host interrupt path. Each line is brought into the local clock domain through a flop chain, turned into an active-high level, and passed through a filter. The filter accepts a new level only after that level has been seen on two consecutive clocks. The two conditioned levels are shown as live, read-only status bits. They sit beside a sticky bus-error flag, which is set by a one-clock strobe from the access logic and cleared by software.

An enable mask selects which of the three status bits take part in a single combined interrupt condition. A small state machine delivers that condition in one of two ways. In the legacy way it sends an assert event when the condition becomes active and a deassert event when it goes away. In the message way it sends one message request, with the programmed address and data, each time the condition rises. Out of reset the block is in legacy mode. Setting the message-enable bit moves delivery to the message way and stops legacy events. Only a single message vector exists.

The delivery state machine has three states. `DS_QUIET` means nothing is outstanding. `DS_INTX_ON` means a legacy assert has been sent. `DS_MSI_WAIT` means a message has been sent and the block is waiting for the condition to drop. Its transitions are:
- QUIET to INTX_ON when the condition is active and legacy delivery is allowed (assert event).
- INTX_ON to QUIET when the condition drops or legacy delivery stops being allowed (deassert event).
- QUIET to MSI_WAIT on a rising condition while message mode is on (message request).
- MSI_WAIT to QUIET when the condition drops or message mode is turned off (no event).

Top module: `irq_mezz_deliver`

## Requirements
- R1: A request pin driven low is reported as 1 in its status bit (pin 0 in bit 0, pin 1 in bit 1). The status bit rises on the fourth rising clock edge after the first edge that samples the low level. A low level that lasts only one clock never appears in the status bit.
- R2: Status bits [1:0] follow the pins. A bit returns to 0 once its pin is released, without any software action, so a source can disappear before it is read.
- R3: A write to the status register (reg_sel_i = 0) has no effect on bits [1:0].
- R4: A bus_err_i strobe sets status bit 2, and the bit stays set. Writing the status register with data bit 2 = 1 clears it. If a strobe and a clear arrive in the same clock, the bit stays set.
- R5: The enable register is written with reg_sel_i = 1. irq_cond_o is the OR over bits [2:0] of (status AND enable).
- R6: After reset, the following are all 0: status_o, enable_o and mode_o (legacy mode, with interrupts not disabled), msi_mmc_o, irq_cond_o, and every event output.
- R7: The mode register is written with reg_sel_i = 2. Bit 0 is interrupt-disable and bit 1 is message-enable. With mode 00, a rise of irq_cond_o produces exactly one intx_assert_o pulse and a fall produces exactly one intx_deassert_o pulse.
- R8: With interrupt-disable set and message-enable clear, changes in irq_cond_o produce no event of any kind.
- R9: With message-enable set, each rise of irq_cond_o produces exactly one msi_req_o pulse. During that pulse, msi_addr_o and msi_data_o carry msg_addr_i and msg_data_i.
- R10: The two delivery modes are exclusive. Message mode produces no legacy events. Switching to message mode while a legacy assert is active produces one deassert event and no message until the condition rises again.
- R11: Only one message vector is offered. msi_mmc_o always reads 0, and msi_data_o carries the programmed data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_n_i | input | 2 | Active-low interrupt request pins from the module |
| bus_err_i | input | 1 | One-clock strobe: access timed out |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 mode |
| reg_wdata_i | input | 3 | Register write data |
| msg_addr_i | input | ADDR_W | Programmed message address |
| msg_data_i | input | DATA_W | Programmed message data |
| status_o | output | 3 | {bus error, request 1, request 0} |
| enable_o | output | 3 | Enable mask readback |
| mode_o | output | 2 | {message-enable, interrupt-disable} readback |
| irq_cond_o | output | 1 | Combined interrupt condition |
| intx_assert_o | output | 1 | Legacy assert event pulse |
| intx_deassert_o | output | 1 | Legacy deassert event pulse |
| msi_req_o | output | 1 | Message request pulse |
| msi_addr_o | output | ADDR_W | Message address presented with the request |
| msi_data_o | output | DATA_W | Message data presented with the request |
| msi_mmc_o | output | 3 | Multiple-message capability, fixed at 0 |

## Verification
A delivery state machine left in the wrong state shows up on the event pins within one clock of the next change of the condition. Typical symptoms are an assert without a matching deassert, a missing message, or a second message without a falling edge in between. The bench counts every pulse over a fixed window after each stimulus, so a missing or duplicated event is caught in that same window. A wrong filter count or a missing synchronizer stage moves the status edge off the fourth clock, and the latency check detects this directly. A glitch that leaks through shows up as a status bit set after a one-clock pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REQ_N        = 2;
    localparam int SEL_W        = 2;
    localparam int MODE_W       = 2;
    localparam int MMC_W        = 3;

    localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
    localparam logic [SEL_W-1:0] SEL_ENABLE = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MODE   = 2'd2;

    localparam int MODE_BIT_DIS = 0;
    localparam int MODE_BIT_MSI = 1;

    typedef enum logic [1:0] {
        DS_QUIET    = 2'd0,
        DS_INTX_ON  = 2'd1,
        DS_MSI_WAIT = 2'd2
    } deliv_state_t;
endpackage

// File: rtl/irq_pin_cond.sv
// One request pin: synchronize, invert to active-high, accept a new level
// only after it has been held for FILT_LEN consecutive samples.
module irq_pin_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic [CW-1:0]          run_q;
    logic                   level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign samp = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (samp == level_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            level_q <= samp;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/irq_stat_regs.sv
// Status (live levels + sticky bus error), enable mask, mode bits, combined condition.
module irq_stat_regs
    import irq_pkg::*;
#(
    parameter int N_REQ = REQ_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_REQ-1:0]   req_lvl,
    input  logic               bus_err,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [N_REQ:0]     reg_wdata,
    output logic [N_REQ:0]     status,
    output logic [N_REQ:0]     enable,
    output logic [MODE_W-1:0]  mode,
    output logic               cond
);
    logic              berr_q;
    logic [N_REQ:0]    en_q;
    logic [MODE_W-1:0] mode_q;
    logic              clr_berr;

    assign clr_berr = reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[N_REQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        berr_q <= 1'b0;
        else if (bus_err)  berr_q <= 1'b1;
        else if (clr_berr) berr_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_ENABLE) en_q   <= reg_wdata;
            if (reg_sel == SEL_MODE)   mode_q <= reg_wdata[MODE_W-1:0];
        end
    end

    assign status = {berr_q, req_lvl};
    assign enable = en_q;
    assign mode   = mode_q;
    assign cond   = |(status & en_q);
endmodule

// File: rtl/irq_deliver_fsm.sv
// Chooses legacy level events or a single message per rising condition.
module irq_deliver_fsm
    import irq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic [DATA_W-1:0] msg_data,
    output logic              intx_assert,
    output logic              intx_deassert,
    output logic              msi_req,
    output logic [ADDR_W-1:0] msi_addr,
    output logic [DATA_W-1:0] msi_data
);
    deliv_state_t state_q, state_d;
    logic         cond_q;
    logic         intx_ok;
    logic         msi_on;

    assign msi_on  = mode[MODE_BIT_MSI];
    assign intx_ok = !mode[MODE_BIT_MSI] && !mode[MODE_BIT_DIS];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_QUIET: begin
                if (cond && intx_ok)                  state_d = DS_INTX_ON;
                else if (cond && msi_on && !cond_q)   state_d = DS_MSI_WAIT;
            end
            DS_INTX_ON: begin
                if (!(cond && intx_ok))               state_d = DS_QUIET;
            end
            DS_MSI_WAIT: begin
                if (!cond || !msi_on)                 state_d = DS_QUIET;
            end
            default:                                  state_d = DS_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_QUIET;
            cond_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cond_q  <= cond;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intx_assert   <= 1'b0;
            intx_deassert <= 1'b0;
            msi_req       <= 1'b0;
            msi_addr      <= '0;
            msi_data      <= '0;
        end else begin
            intx_assert   <= (state_q != DS_INTX_ON) && (state_d == DS_INTX_ON);
            intx_deassert <= (state_q == DS_INTX_ON) && (state_d != DS_INTX_ON);
            msi_req       <= (state_q == DS_QUIET) && (state_d == DS_MSI_WAIT);
            if ((state_q == DS_QUIET) && (state_d == DS_MSI_WAIT)) begin
                msi_addr <= msg_addr;
                msi_data <= msg_data;
            end
        end
    end
endmodule

// File: rtl/irq_mezz_deliver.sv
module irq_mezz_deliver
    import irq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_n_i,
    input  logic              bus_err_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [2:0]        reg_wdata_i,
    input  logic [ADDR_W-1:0] msg_addr_i,
    input  logic [DATA_W-1:0] msg_data_i,
    output logic [2:0]        status_o,
    output logic [2:0]        enable_o,
    output logic [1:0]        mode_o,
    output logic              irq_cond_o,
    output logic              intx_assert_o,
    output logic              intx_deassert_o,
    output logic              msi_req_o,
    output logic [ADDR_W-1:0] msi_addr_o,
    output logic [DATA_W-1:0] msi_data_o,
    output logic [2:0]        msi_mmc_o
);
    logic [REQ_N-1:0] req_lvl;

    for (genvar g = 0; g < REQ_N; g++) begin : g_pin
        irq_pin_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_pin (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_n(req_n_i[g]),
            .level(req_lvl[g])
        );
    end

    irq_stat_regs #(.N_REQ(REQ_N)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_lvl  (req_lvl),
        .bus_err  (bus_err_i),
        .reg_wr   (reg_wr_i),
        .reg_sel  (reg_sel_i),
        .reg_wdata(reg_wdata_i),
        .status   (status_o),
        .enable   (enable_o),
        .mode     (mode_o),
        .cond     (irq_cond_o)
    );

    irq_deliver_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond         (irq_cond_o),
        .mode         (mode_o),
        .msg_addr     (msg_addr_i),
        .msg_data     (msg_data_i),
        .intx_assert  (intx_assert_o),
        .intx_deassert(intx_deassert_o),
        .msi_req      (msi_req_o),
        .msi_addr     (msi_addr_o),
        .msi_data     (msi_data_o)
    );

    assign msi_mmc_o = '0;
endmodule

// File: rtl/irq_mezz_deliver_chk.sv
module irq_mezz_deliver_chk
    import irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_n,
    input logic       bus_err,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic       wr_berr,
    input logic [2:0] status,
    input logic [1:0] mode,
    input logic       irq_cond,
    input logic       intx_assert,
    input logic       intx_deassert,
    input logic       msi_req
);
    logic intx_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             intx_lvl <= 1'b0;
        else if (intx_assert)   intx_lvl <= 1'b1;
        else if (intx_deassert) intx_lvl <= 1'b0;
    end

    AST_REQ0_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (!$past(req_n[0], 3) && !$past(req_n[0], 4))); // R1
    AST_REQ1_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> (!$past(req_n[1], 3) && !$past(req_n[1], 4))); // R1
    AST_BERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> status[2]); // R4
    AST_BERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !(reg_wr && reg_sel == SEL_STATUS && wr_berr)) |=> status[2]); // R4
    AST_INTX_ASSERT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        intx_assert |-> !intx_lvl); // R7
    AST_INTX_DEASSERT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        intx_deassert |-> intx_lvl); // R7
    AST_INTX_ONLY_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        intx_assert |-> ($past(mode) == 2'b00)); // R8
    AST_MSI_ONLY_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> $past(mode[MODE_BIT_MSI])); // R10
    AST_MSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> ($past(irq_cond) && !$past(irq_cond, 2))); // R9
    AST_NO_DUAL_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(msi_req && intx_assert)); // R10
endmodule

bind irq_mezz_deliver irq_mezz_deliver_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_n        (req_n_i),
    .bus_err      (bus_err_i),
    .reg_wr       (reg_wr_i),
    .reg_sel      (reg_sel_i),
    .wr_berr      (reg_wdata_i[2]),
    .status       (status_o),
    .mode         (mode_o),
    .irq_cond     (irq_cond_o),
    .intx_assert  (intx_assert_o),
    .intx_deassert(intx_deassert_o),
    .msi_req      (msi_req_o)
);

// File: tb/sim_irq_mezz_deliver.sv
module sim_irq_mezz_deliver;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int NV = 22;

    typedef struct packed {
        logic [1:0] pins;
        logic       berr;
        logic       wr;
        logic [1:0] sel;
        logic [2:0] wdata;
        logic [2:0] estat;
        logic       econd;
        logic [1:0] nas;
        logic [1:0] nde;
        logic [1:0] nmsi;
    } vec_t;

    // pins, berr, wr, sel, wdata, status, cond, #assert, #deassert, #msg
    localparam vec_t VECS [NV] = '{
        '{2'b11,1'b0,1'b1,2'd1,3'b111, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R5 enable all
        '{2'b10,1'b0,1'b0,2'd0,3'b000, 3'b001,1'b1, 2'd1,2'd0,2'd0}, // R7 pin0 assert
        '{2'b11,1'b0,1'b0,2'd0,3'b000, 3'b000,1'b0, 2'd0,2'd1,2'd0}, // R2 release
        '{2'b11,1'b1,1'b0,2'd0,3'b000, 3'b100,1'b1, 2'd1,2'd0,2'd0}, // R4 bus error
        '{2'b01,1'b0,1'b1,2'd0,3'b011, 3'b110,1'b1, 2'd0,2'd0,2'd0}, // R3 write ignored
        '{2'b01,1'b0,1'b1,2'd0,3'b100, 3'b010,1'b1, 2'd0,2'd0,2'd0}, // R4 clear
        '{2'b11,1'b0,1'b0,2'd0,3'b000, 3'b000,1'b0, 2'd0,2'd1,2'd0}, // R7 fall
        '{2'b11,1'b0,1'b1,2'd2,3'b001, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R8 disable
        '{2'b10,1'b0,1'b0,2'd0,3'b000, 3'b001,1'b1, 2'd0,2'd0,2'd0}, // R8 silent
        '{2'b11,1'b0,1'b0,2'd0,3'b000, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R8 silent
        '{2'b11,1'b0,1'b1,2'd2,3'b010, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R9 msg mode
        '{2'b10,1'b0,1'b0,2'd0,3'b000, 3'b001,1'b1, 2'd0,2'd0,2'd1}, // R9 one msg
        '{2'b00,1'b0,1'b0,2'd0,3'b000, 3'b011,1'b1, 2'd0,2'd0,2'd0}, // R9 no repeat
        '{2'b11,1'b0,1'b0,2'd0,3'b000, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R10 no deassert
        '{2'b01,1'b0,1'b0,2'd0,3'b000, 3'b010,1'b1, 2'd0,2'd0,2'd1}, // R9 second rise
        '{2'b01,1'b0,1'b1,2'd1,3'b000, 3'b010,1'b0, 2'd0,2'd0,2'd0}, // R5 mask off
        '{2'b01,1'b0,1'b1,2'd1,3'b010, 3'b010,1'b1, 2'd0,2'd0,2'd1}, // R5 unmask rise
        '{2'b11,1'b0,1'b1,2'd1,3'b111, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R5 all on
        '{2'b11,1'b0,1'b1,2'd2,3'b000, 3'b000,1'b0, 2'd0,2'd0,2'd0}, // R7 legacy
        '{2'b10,1'b0,1'b0,2'd0,3'b000, 3'b001,1'b1, 2'd1,2'd0,2'd0}, // R7 assert
        '{2'b10,1'b0,1'b1,2'd2,3'b010, 3'b001,1'b1, 2'd0,2'd1,2'd0}, // R10 switch
        '{2'b11,1'b0,1'b0,2'd0,3'b000, 3'b000,1'b0, 2'd0,2'd0,2'd0}  // R10 quiet
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_n = 2'b11;
    logic          bus_err = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [2:0]    reg_wdata = 3'd0;
    logic [AW-1:0] msg_addr = 32'hFEE0_1000;
    logic [DW-1:0] msg_data = 16'h4021;
    logic [2:0]    status, enable, mmc;
    logic [1:0]    mode;
    logic          cond, i_as, i_de, m_req;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;

    int checks = 0;
    int fails  = 0;
    int c_as, c_de, c_msi;
    bit done = 0;

    always #5 clk = ~clk;

    irq_mezz_deliver u0 (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .bus_err_i(bus_err),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .msg_addr_i(msg_addr), .msg_data_i(msg_data),
        .status_o(status), .enable_o(enable), .mode_o(mode), .irq_cond_o(cond),
        .intx_assert_o(i_as), .intx_deassert_o(i_de), .msi_req_o(m_req),
        .msi_addr_o(m_addr), .msi_data_o(m_data), .msi_mmc_o(mmc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_count();
        @(posedge clk);
        @(negedge clk);
        c_as  += int'(i_as);
        c_de  += int'(i_de);
        c_msi += int'(m_req);
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [2:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk("R6 status", 64'(status), 64'd0);
        chk("R6 enable", 64'(enable), 64'd0);
        chk("R6 mode", 64'(mode), 64'd0);
        chk("R6 events", 64'({cond, i_as, i_de, m_req}), 64'd0);
        chk("R11 mmc", 64'(mmc), 64'd0);

        for (int v = 0; v < NV; v++) begin
            req_n = VECS[v].pins; bus_err = VECS[v].berr; reg_wr = VECS[v].wr;
            reg_sel = VECS[v].sel; reg_wdata = VECS[v].wdata;
            c_as = 0; c_de = 0; c_msi = 0;
            for (int k = 0; k < 7; k++) begin
                tick_count();
                if (k == 0) begin bus_err = 1'b0; reg_wr = 1'b0; end
            end
            chk($sformatf("R2/R3/R4 vec%0d status", v), 64'(status), 64'(VECS[v].estat));
            chk($sformatf("R5 vec%0d cond", v), 64'(cond), 64'(VECS[v].econd));
            chk($sformatf("R7 vec%0d asserts", v), 64'(c_as), 64'(VECS[v].nas));
            chk($sformatf("R8/R10 vec%0d deasserts", v), 64'(c_de), 64'(VECS[v].nde));
            chk($sformatf("R9 vec%0d messages", v), 64'(c_msi), 64'(VECS[v].nmsi));
        end

        // R1 latency and glitch rejection (legacy mode, all enabled)
        do_write(2'd2, 3'b000);
        req_n = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 not yet after 3 edges", 64'(status[0]), 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R1 set after 4 edges", 64'(status[0]), 64'd1);
        req_n = 2'b11;
        repeat (8) @(negedge clk);
        chk("R2 released", 64'(status[0]), 64'd0);

        c_as = 0; c_de = 0; c_msi = 0;
        begin
            int seen = 0;
            req_n = 2'b01;
            @(negedge clk);
            req_n = 2'b11;
            for (int k = 0; k < 8; k++) begin
                tick_count();
                seen += int'(status[1]);
            end
            chk("R1 one-clock glitch hidden", 64'(seen), 64'd0);
            chk("R1 glitch no event", 64'(c_as + c_de), 64'd0);
            seen = 0;
            req_n = 2'b01;
            repeat (2) @(negedge clk);
            req_n = 2'b11;
            for (int k = 0; k < 8; k++) begin
                tick_count();
                seen += int'(status[1]);
            end
            chk("R1 two-clock pulse seen", 64'(seen > 0), 64'd1);
            chk("R7 two-clock pulse events", 64'({c_as[1:0], c_de[1:0]}), 64'b0101);
        end

        // R9/R11 message address and data
        do_write(2'd2, 3'b010);
        msg_addr = 32'hFEE0_2468;
        msg_data = 16'hB00C;
        req_n = 2'b01;
        begin
            bit got = 0;
            for (int k = 0; k < 8; k++) begin
                @(posedge clk); @(negedge clk);
                if (m_req) begin
                    got = 1;
                    chk("R9 msg address", 64'(m_addr), 64'h0000_0000_FEE0_2468);
                    chk("R11 msg data unchanged", 64'(m_data), 64'h0000_0000_0000_B00C);
                    chk("R11 mmc zero", 64'(mmc), 64'd0);
                end
                chk("R10 no legacy in msg mode", 64'({i_as, i_de}), 64'd0);
            end
            chk("R9 message seen", 64'(got), 64'd1);
        end
        req_n = 2'b11;
        repeat (8) @(negedge clk);

        // R4 set wins over clear in the same clock
        bus_err = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 3'b100;
        @(posedge clk); @(negedge clk);
        bus_err = 1'b0; reg_wr = 1'b0;
        chk("R4 set beats clear", 64'(status[2]), 64'd1);
        do_write(2'd0, 3'b100);
        chk("R4 cleared", 64'(status[2]), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule